// File: doc/BRIEF.md
# Delay-Sweep Window-Centering Calibration Controller

This block tunes the timing of a memory interface after power-up. Seed delays that already allow basic reads and writes are loaded first. The block then runs three calibrations, always in the same order: write strobe against the clock, read strobe against the returned data, and the read strobe gate against the incoming strobe. The gate setting has to open the internal strobe path inside the read preamble and close it inside the postamble. The strobe line is bidirectional, so it must be masked whenever the bus turns around between reads and writes.

For each calibration, the controller steps a delay code upward by one, from zero to a programmable limit. At every code it asks an external pattern checker to run a write/read test, then waits for that checker to report done with a pass or fail bit. The controller tracks the longest unbroken run of passing codes. The final setting is the midpoint of that run, which gives the widest margin on both sides. The run length is reported as the window width. If no code passes, a per-calibration error flag is raised and the seed value is kept. When all three calibrations are finished, a single done pulse marks the final codes as valid.

Top module: `dly_cal_ctrl`

## Requirements
- R1: While the synchronous reset is high and on the first cycle after it, the outputs are all zero: busy_o, done_o, test_req_o, err_o, all three delay outputs and all three widths.
- R2: After a start, test requests run first for all codes of calibration 0 (write, test_sel_o=0), then calibration 1 (read, test_sel_o=1), then calibration 2 (gate, test_sel_o=2). Within each calibration, the codes run from 0 to the captured limit in steps of one. Each request is a one-cycle pulse, and the next request comes only after test_done_i has been seen.
- R3: A start in idle captures max_code_i and the three seeds. On the cycle after the start, each delay output shows its seed.
- R4: The window is the longest contiguous run of passing codes. When two runs have the same length, the run with the lowest codes is used.
- R5: A calibration with a non-empty window sets its delay output to (lowest + highest passing code of the window) >> 1, rounding down.
- R6: The width output equals highest − lowest + 1 of the window. It is 0 when no code passes.
- R7: When no code passes, the error bit of that calibration (err_o bit 0 write, bit 1 read, bit 2 gate) is set, and its delay output keeps its seed.
- R8: Each calibration's result is on its delay output before the first test request of the next calibration.
- R9: done_o pulses for exactly one cycle when the gate calibration finishes. In that cycle all results are valid and busy_o is low.
- R10: A start pulse while busy_o is high has no effect on the running sequence.
- R11: A new start clears err_o and the widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse for the calibration sequence |
| max_code_i | input | 8 | Highest delay code to sweep, captured at start |
| seed_wr_i | input | 8 | Seed write-strobe delay |
| seed_rd_i | input | 8 | Seed read-strobe delay |
| seed_gate_i | input | 8 | Seed read-gate delay |
| test_req_o | output | 1 | One-cycle request for a pattern test |
| test_sel_o | output | 2 | Calibration under test (0 write, 1 read, 2 gate) |
| test_code_o | output | 8 | Delay code under test |
| test_done_i | input | 1 | Pattern test finished |
| test_pass_i | input | 1 | Pattern test result, valid with test_done_i |
| wr_dly_o | output | 8 | Write-strobe delay setting |
| rd_dly_o | output | 8 | Read-strobe delay setting |
| gate_dly_o | output | 8 | Read-gate delay setting |
| wr_width_o | output | 9 | Write window width |
| rd_width_o | output | 9 | Read window width |
| gate_width_o | output | 9 | Gate window width |
| err_o | output | 3 | No-pass flags per calibration |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of the sequence |

## Verification
The assertions assume that the pattern checker raises test_done_i only while a request is outstanding, for one cycle at a time, and never in the same cycle as the request pulse. The bench responder waits at least one full cycle after each request and varies that latency with the code. It then drops test_done_i on the following cycle. The pass patterns are chosen to cover the following cases:
- split windows;
- windows of equal length;
- a window that touches the top code;
- a one-code sweep;
- a calibration with no passing code.

// File: rtl/dly_cal_pkg.sv
package dly_cal_pkg;
    localparam int NUM_CAL = 3;
    localparam int SEL_W   = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REQ    = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } cal_state_e;
endpackage

// File: rtl/dcal_run_track.sv
module dcal_run_track #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              smp_i,
    input  logic              pass_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] best_start_o,
    output logic [CODE_W:0]   best_len_o
);
    localparam logic [CODE_W:0] LEN_ONE = 1;

    typedef struct packed {
        logic [CODE_W-1:0] run_start;
        logic [CODE_W:0]   run_len;
        logic [CODE_W-1:0] best_start;
        logic [CODE_W:0]   best_len;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [CODE_W:0]   new_len;
    logic [CODE_W-1:0] new_start;

    always_comb begin
        trk_d     = trk_q;
        new_len   = (trk_q.run_len == '0) ? LEN_ONE : trk_q.run_len + LEN_ONE;
        new_start = (trk_q.run_len == '0) ? code_i : trk_q.run_start;
        if (clr_i) begin
            trk_d = '0;
        end else if (smp_i) begin
            if (pass_i) begin
                trk_d.run_len   = new_len;
                trk_d.run_start = new_start;
                // strictly longer only: an equal later run keeps the earlier one
                if (new_len > trk_q.best_len) begin
                    trk_d.best_len   = new_len;
                    trk_d.best_start = new_start;
                end
            end else begin
                trk_d.run_len = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) trk_q <= '0;
        else     trk_q <= trk_d;
    end

    assign best_start_o = trk_q.best_start;
    assign best_len_o   = trk_q.best_len;
endmodule

// File: rtl/dcal_mid_calc.sv
module dcal_mid_calc #(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] start_i,
    input  logic [CODE_W:0]   len_i,
    output logic [CODE_W-1:0] mid_o,
    output logic [CODE_W:0]   width_o,
    output logic              empty_o
);
    localparam logic [CODE_W:0] ONE = 1;

    logic [CODE_W:0] hi_ext;
    logic [CODE_W:0] sum;

    always_comb begin
        hi_ext  = {1'b0, start_i} + len_i - ONE;
        sum     = {1'b0, start_i} + hi_ext;
        mid_o   = sum[CODE_W:1];
        width_o = len_i;
        empty_o = (len_i == '0);
    end
endmodule

// File: rtl/dly_cal_ctrl.sv
module dly_cal_ctrl
    import dly_cal_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CODE_W-1:0] max_code_i,
    input  logic [CODE_W-1:0] seed_wr_i,
    input  logic [CODE_W-1:0] seed_rd_i,
    input  logic [CODE_W-1:0] seed_gate_i,
    output logic              test_req_o,
    output logic [SEL_W-1:0]  test_sel_o,
    output logic [CODE_W-1:0] test_code_o,
    input  logic              test_done_i,
    input  logic              test_pass_i,
    output logic [CODE_W-1:0] wr_dly_o,
    output logic [CODE_W-1:0] rd_dly_o,
    output logic [CODE_W-1:0] gate_dly_o,
    output logic [CODE_W:0]   wr_width_o,
    output logic [CODE_W:0]   rd_width_o,
    output logic [CODE_W:0]   gate_width_o,
    output logic [NUM_CAL-1:0] err_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [CODE_W-1:0] CODE_ONE = 1;
    localparam logic [SEL_W-1:0]  SEL_ONE  = 1;
    localparam logic [SEL_W-1:0]  SEL_LAST = SEL_W'(NUM_CAL - 1);

    typedef struct packed {
        cal_state_e                       st;
        logic [SEL_W-1:0]                 sel;
        logic [CODE_W-1:0]                code;
        logic [CODE_W-1:0]                max;
        logic [NUM_CAL-1:0][CODE_W-1:0]   dly;
        logic [NUM_CAL-1:0][CODE_W:0]     width;
        logic [NUM_CAL-1:0]               err;
        logic                             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              trk_clr, trk_smp;
    logic [CODE_W-1:0] best_start;
    logic [CODE_W:0]   best_len;
    logic [CODE_W-1:0] win_mid;
    logic [CODE_W:0]   win_width;
    logic              win_empty;

    dcal_run_track #(.CODE_W(CODE_W)) trk_i (
        .clk         (clk),
        .rst         (rst),
        .clr_i       (trk_clr),
        .smp_i       (trk_smp),
        .pass_i      (test_pass_i),
        .code_i      (ctl_q.code),
        .best_start_o(best_start),
        .best_len_o  (best_len)
    );

    dcal_mid_calc #(.CODE_W(CODE_W)) mid_i (
        .start_i(best_start),
        .len_i  (best_len),
        .mid_o  (win_mid),
        .width_o(win_width),
        .empty_o(win_empty)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        trk_clr    = 1'b0;
        trk_smp    = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.max   = max_code_i;
                    ctl_d.dly   = {seed_gate_i, seed_rd_i, seed_wr_i};
                    ctl_d.width = '0;
                    ctl_d.err   = '0;
                    ctl_d.sel   = '0;
                    ctl_d.code  = '0;
                    ctl_d.st    = ST_REQ;
                    trk_clr     = 1'b1;
                end
            end
            ST_REQ: begin
                ctl_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (test_done_i) begin
                    trk_smp = 1'b1;
                    if (ctl_q.code == ctl_q.max) begin
                        ctl_d.st = ST_FINISH;
                    end else begin
                        ctl_d.code = ctl_q.code + CODE_ONE;
                        ctl_d.st   = ST_REQ;
                    end
                end
            end
            ST_FINISH: begin
                trk_clr = 1'b1;
                if (win_empty) begin
                    ctl_d.err[ctl_q.sel]   = 1'b1;
                    ctl_d.width[ctl_q.sel] = '0;
                end else begin
                    ctl_d.dly[ctl_q.sel]   = win_mid;
                    ctl_d.width[ctl_q.sel] = win_width;
                end
                if (ctl_q.sel == SEL_LAST) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                end else begin
                    ctl_d.sel  = ctl_q.sel + SEL_ONE;
                    ctl_d.code = '0;
                    ctl_d.st   = ST_REQ;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign test_req_o  = (ctl_q.st == ST_REQ);
    assign test_sel_o  = ctl_q.sel;
    assign test_code_o = ctl_q.code;
    assign err_o       = ctl_q.err;
    assign busy_o      = (ctl_q.st != ST_IDLE);
    assign done_o      = ctl_q.done;

    logic [NUM_CAL-1:0][CODE_W-1:0] dly_vec;
    logic [NUM_CAL-1:0][CODE_W:0]   wid_vec;

    for (genvar g = 0; g < NUM_CAL; g++) begin : g_res
        assign dly_vec[g] = ctl_q.dly[g];
        assign wid_vec[g] = ctl_q.width[g];
    end

    assign wr_dly_o     = dly_vec[0];
    assign rd_dly_o     = dly_vec[1];
    assign gate_dly_o   = dly_vec[2];
    assign wr_width_o   = wid_vec[0];
    assign rd_width_o   = wid_vec[1];
    assign gate_width_o = wid_vec[2];
endmodule

// File: rtl/dly_cal_chk.sv
module dly_cal_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              test_req_o,
    input logic [1:0]        test_sel_o,
    input logic              done_o,
    input logic              busy_o,
    input logic [2:0]        err_o,
    input logic [CODE_W:0]   wr_width_o,
    input logic [CODE_W:0]   rd_width_o,
    input logic [CODE_W:0]   gate_width_o
);
    a_r2_req_single: assert property (@(posedge clk) disable iff (rst)
        test_req_o |=> !test_req_o);

    a_r2_sel_valid: assert property (@(posedge clk) disable iff (rst)
        test_req_o |-> (test_sel_o != 2'd3));

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    a_r7_wr_err_width: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (err_o[0] == (wr_width_o == '0)));

    a_r7_rd_err_width: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (err_o[1] == (rd_width_o == '0)));

    a_r7_gate_err_width: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (err_o[2] == (gate_width_o == '0)));
endmodule

bind dly_cal_ctrl dly_cal_chk #(.CODE_W(CODE_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .test_req_o  (test_req_o),
    .test_sel_o  (test_sel_o),
    .done_o      (done_o),
    .busy_o      (busy_o),
    .err_o       (err_o),
    .wr_width_o  (wr_width_o),
    .rd_width_o  (rd_width_o),
    .gate_width_o(gate_width_o)
);

// File: tb/dly_cal_ctrl_tb_top.sv
module dly_cal_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] max_code_i = '0;
    logic [7:0] seed_wr_i = '0, seed_rd_i = '0, seed_gate_i = '0;
    logic       test_done_i = 1'b0, test_pass_i = 1'b0;
    logic       test_req_o, busy_o, done_o;
    logic [1:0] test_sel_o;
    logic [7:0] test_code_o, wr_dly_o, rd_dly_o, gate_dly_o;
    logic [8:0] wr_width_o, rd_width_o, gate_width_o;
    logic [2:0] err_o;

    always #4 clk = ~clk;

    dly_cal_ctrl dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .max_code_i(max_code_i),
        .seed_wr_i(seed_wr_i), .seed_rd_i(seed_rd_i), .seed_gate_i(seed_gate_i),
        .test_req_o(test_req_o), .test_sel_o(test_sel_o), .test_code_o(test_code_o),
        .test_done_i(test_done_i), .test_pass_i(test_pass_i),
        .wr_dly_o(wr_dly_o), .rd_dly_o(rd_dly_o), .gate_dly_o(gate_dly_o),
        .wr_width_o(wr_width_o), .rd_width_o(rd_width_o), .gate_width_o(gate_width_o),
        .err_o(err_o), .busy_o(busy_o), .done_o(done_o)
    );

    int errors = 0;
    int checks = 0;
    int scen   = 0;
    int q_sel[$];
    int q_code[$];
    int exp_dly[3];
    int exp_w[3];
    int exp_err[3];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit pass_of(input int s, input int sel, input int c);
        case (s)
            1: case (sel)
                   0: return (c >= 4 && c <= 10);
                   1: return (c >= 2 && c <= 3) || (c >= 8 && c <= 12);
                   default: return 1'b0;
               endcase
            2: return (sel != 1);
            3: case (sel)
                   0: return 1'b1;
                   1: return (c >= 10 && c <= 19) || (c >= 100 && c <= 109);
                   default: return (c >= 250);
               endcase
            default: case (sel)
                   0: return (c >= 1 && c <= 6);
                   1: return (c % 2 == 0);
                   default: return (c <= 2);
               endcase
        endcase
    endfunction

    // behavioural window search: longest run, earliest on ties
    task automatic model(input int s, input int maxc, input int seeds[3]);
        for (int sel = 0; sel < 3; sel++) begin
            int rs = 0, rl = 0, bs = 0, bl = 0;
            for (int c = 0; c <= maxc; c++) begin
                if (pass_of(s, sel, c)) begin
                    if (rl == 0) rs = c;
                    rl++;
                    if (rl > bl) begin bl = rl; bs = rs; end
                end else rl = 0;
            end
            exp_w[sel]   = bl;
            exp_err[sel] = (bl == 0);
            exp_dly[sel] = (bl == 0) ? seeds[sel] : (bs + bs + bl - 1) / 2;
        end
    endtask

    // pattern-checker responder with code-dependent latency
    initial begin
        forever begin
            @(negedge clk);
            test_done_i = 1'b0;
            if (test_req_o) begin
                int s_sel, s_code, lat;
                s_sel  = int'(test_sel_o);
                s_code = int'(test_code_o);
                if (q_sel.size() == 0) begin
                    chk(1'b0, "R2 unexpected request", s_code, -1);
                end else begin
                    int e_sel, e_code;
                    e_sel  = q_sel.pop_front();
                    e_code = q_code.pop_front();
                    chk(s_sel == e_sel, "R2 calibration order", s_sel, e_sel);
                    chk(s_code == e_code, "R2 code sequence", s_code, e_code);
                    if (e_code == 0 && e_sel == 1)
                        chk(int'(wr_dly_o) == exp_dly[0], "R8 write result before read sweep", int'(wr_dly_o), exp_dly[0]);
                    if (e_code == 0 && e_sel == 2)
                        chk(int'(rd_dly_o) == exp_dly[1], "R8 read result before gate sweep", int'(rd_dly_o), exp_dly[1]);
                end
                lat = 1 + (s_code % 3);
                repeat (lat) @(negedge clk);
                test_pass_i = pass_of(scen, s_sel, s_code);
                test_done_i = 1'b1;
            end
        end
    end

    task automatic run_scen(input int s, input int maxc, input int sw, input int sr, input int sg,
                            input bit poke_start);
        int seeds[3];
        int n;
        seeds[0] = sw; seeds[1] = sr; seeds[2] = sg;
        scen = s;
        model(s, maxc, seeds);
        for (int sel = 0; sel < 3; sel++)
            for (int c = 0; c <= maxc; c++) begin
                q_sel.push_back(sel);
                q_code.push_back(c);
            end
        @(negedge clk);
        max_code_i  = 8'(maxc);
        seed_wr_i   = 8'(sw);
        seed_rd_i   = 8'(sr);
        seed_gate_i = 8'(sg);
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        max_code_i = 8'd3;
        seed_wr_i = 8'd99;
        chk(wr_dly_o == 8'(sw), "R3 write seed loaded", int'(wr_dly_o), sw);
        chk(rd_dly_o == 8'(sr), "R3 read seed loaded", int'(rd_dly_o), sr);
        chk(gate_dly_o == 8'(sg), "R3 gate seed loaded", int'(gate_dly_o), sg);
        chk(err_o == 3'b000, "R11 errors cleared at start", int'(err_o), 0);
        chk(wr_width_o == 9'd0, "R11 widths cleared at start", int'(wr_width_o), 0);
        chk(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
        if (poke_start) begin
            repeat (5) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        n = 0;
        while (!done_o && n < 50000) begin
            @(negedge clk);
            n++;
        end
        chk(done_o == 1'b1, "R9 done pulse seen", int'(done_o), 1);
        chk(busy_o == 1'b0, "R9 not busy at done", int'(busy_o), 0);
        chk(q_sel.size() == 0, "R2 every code requested", q_sel.size(), 0);
        chk(int'(wr_dly_o) == exp_dly[0], "R5 write delay midpoint", int'(wr_dly_o), exp_dly[0]);
        chk(int'(rd_dly_o) == exp_dly[1], "R4 read delay of longest run", int'(rd_dly_o), exp_dly[1]);
        chk(int'(gate_dly_o) == exp_dly[2], "R7 gate delay", int'(gate_dly_o), exp_dly[2]);
        chk(int'(wr_width_o) == exp_w[0], "R6 write width", int'(wr_width_o), exp_w[0]);
        chk(int'(rd_width_o) == exp_w[1], "R6 read width", int'(rd_width_o), exp_w[1]);
        chk(int'(gate_width_o) == exp_w[2], "R6 gate width", int'(gate_width_o), exp_w[2]);
        chk(int'(err_o) == exp_err[0] + 2*exp_err[1] + 4*exp_err[2], "R7 error flags",
            int'(err_o), exp_err[0] + 2*exp_err[1] + 4*exp_err[2]);
        @(negedge clk);
        chk(done_o == 1'b0, "R9 done lasts one cycle", int'(done_o), 0);
        if (poke_start) begin
            repeat (20) @(negedge clk);
            chk(busy_o == 1'b0 && q_sel.size() == 0, "R10 ignored start caused no rerun",
                int'(busy_o), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0 && done_o == 1'b0 && test_req_o == 1'b0, "R1 idle in reset",
            int'({busy_o, done_o, test_req_o}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(err_o == 3'b000 && wr_dly_o == 8'd0 && rd_dly_o == 8'd0 && gate_dly_o == 8'd0,
            "R1 zero results after reset", int'(wr_dly_o), 0);
        chk(wr_width_o == 9'd0 && rd_width_o == 9'd0 && gate_width_o == 9'd0,
            "R1 zero widths after reset", int'(wr_width_o), 0);
        // split read windows, gate never passes
        run_scen(1, 15, 20, 21, 22, 1'b0);
        // single-code sweep, flags from previous run cleared
        run_scen(2, 0, 5, 6, 7, 1'b0);
        // full range, equal-length runs, window touching the top code
        run_scen(3, 255, 1, 2, 3, 1'b0);
        // start pulse during a sweep
        run_scen(4, 7, 9, 9, 9, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule